// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Collector

This block merges the request lines of many peripheral sources into a single processor interrupt line. Each source has a two-bit priority level, an enable and a software-force bit. Among the sources that are enabled and requesting, an arbiter picks one winner. The highest level wins, and on a tie the lowest source number wins. The winner is turned into a handler address: a programmable base plus four times the source number.

The processor reads the vector register to find out which handler to run. When the read side-effect mode is on, that same read marks the winner's level as in service. A level that is in service masks every request at that level or below it, so only a strictly higher level can interrupt a running handler. Software ends a handler by writing a one-hot level-acknowledge word. The control register and the priority registers each have set and clear alias addresses, so that single bits can be changed without a read-modify-write.

All registers are reached over a simple single-cycle read/write bus with word addresses. Read data appears on the cycle after the request.

Top module: `irq_collector`

## Requirements
- R1: After reset, and with no write yet done, the control register, the vector base and every priority register read 0, every source is disabled at level 0, and `irq_o` is low.
- R2: Priority register k sits at word address 0x10+4k and holds sources 4k..4k+3, one byte each: source n uses byte lane n%4. Within a byte, bits [1:0] are the level, bit 2 is the enable and bit 3 is the software force. The other four bits of each byte read 0.
- R3: Each of the control register (0x00) and priority register k (0x10+4k) has two aliases. A write to address+1 ORs the written ones into the register, and a write to address+2 clears the written ones; no other bit changes.
- R4: `irq_o` goes high on the cycle after some enabled source has a pending request (its `src_req` line or its force bit) at a level strictly above every level in service. This happens only while control bit 1 (final enable) is set.
- R5: The winner is the pending source with the highest level. Among pending sources at that level, the lowest-numbered one wins.
- R6: A read of address 0x04 returns the vector base (address 0x06, read/write) plus 4 times the winner's number. The value appears on `bus_rdata` one cycle after the read.
- R7: When control bit 0 (read side-effect mode) is set, a vector read that finds an eligible winner marks the winner's level as in service. When the bit is clear, vector reads change no state.
- R8: While a level is in service, pending sources at that level or below it do not raise `irq_o`. A source at a strictly higher level does.
- R9: A write to address 0x05 with bit L set clears the in-service state of level L. Levels whose bits are zero keep their state.
- R10: When no source is eligible, a vector read returns the vector base and marks no level as in service.
- R11: A write of a one to control bit 31, through the plain or the set address, returns all registers, the in-service state, `bus_rdata` and `irq_o` to their reset values on the next cycle.
- R12: A source whose enable bit is clear takes no part in arbitration, whatever its request or force bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered, valid the cycle after a read |
| src_req | input | NUM_SRC | Level-sensitive source request lines |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The bench steps through every source on its own while all other request lines are high. This catches a wrong byte lane, a wrong vector offset, or disabled neighbours that still take part in arbitration. A sweep over many level and request patterns compares the vector with a winner computed in the bench; an arbiter that breaks ties toward the higher index, or that compares levels with the wrong order, returns a different address. A nesting sequence checks that a request at the level already in service stays masked, and that a higher level still gets through. It also checks that acknowledging the wrong level releases nothing, which a design with `>=` in place of `>`, or with a mis-decoded acknowledge, would get wrong. Three further checks each follow a state change on a later request: that an idle vector read marks no level, that vector reads with side effects off have no effect, and that soft reset clears the in-service state.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int LVL_W   = 2;
  localparam int NUM_LVL = 1 << LVL_W;
  localparam int LANE_W  = 8;

  // field positions inside one source byte
  localparam int F_LVL_LO = 0;
  localparam int F_EN     = 2;
  localparam int F_FORCE  = 3;
  localparam logic [LANE_W-1:0] LANE_MASK = 8'h0F;

  // control register bits
  localparam int C_RSE   = 0;
  localparam int C_FINAL = 1;
  localparam int C_SRST  = 31;

  // word addresses
  localparam int A_CTRL  = 'h00;
  localparam int A_VEC   = 'h04;
  localparam int A_LACK  = 'h05;
  localparam int A_VBASE = 'h06;
  localparam int A_PRIO0 = 'h10;
  localparam int PRIO_STRIDE = 4;

  typedef enum logic [1:0] {
    OP_WR   = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } alias_e;

  typedef logic [LVL_W-1:0] lvl_t;

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  localparam int SPR     = DATA_W / LANE_W,
  localparam int NUM_REG = (NUM_SRC + SPR - 1) / SPR
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output logic                              soft_rst,
  output logic [DATA_W-1:0]                 ctrl_word,
  output logic                              ctl_rse,
  output logic                              ctl_final,
  output logic [DATA_W-1:0]                 vbase,
  output logic [NUM_REG-1:0][DATA_W-1:0]    prio_words,
  output logic [NUM_SRC-1:0][LVL_W-1:0]     src_lvl,
  output logic [NUM_SRC-1:0]                src_en,
  output logic [NUM_SRC-1:0]                src_frc
);

  localparam logic [DATA_W-1:0] CMASK = (DATA_W'(1) << C_RSE) | (DATA_W'(1) << C_FINAL);
  localparam logic [DATA_W-1:0] PMASK = {SPR{LANE_MASK}};

  function automatic alias_e decode(input logic [ADDR_W-1:0] a, input int base);
    if (a == ADDR_W'(base))          return OP_WR;
    else if (a == ADDR_W'(base + 1)) return OP_SET;
    else if (a == ADDR_W'(base + 2)) return OP_CLR;
    else                             return OP_NONE;
  endfunction

  function automatic logic [DATA_W-1:0] apply_op(input alias_e op,
                                                 input logic [DATA_W-1:0] cur,
                                                 input logic [DATA_W-1:0] w);
    case (op)
      OP_WR:   return w;
      OP_SET:  return cur | w;
      OP_CLR:  return cur & ~w;
      default: return cur;
    endcase
  endfunction

  logic [DATA_W-1:0] ctrl_q;
  alias_e            ctrl_op;
  alias_e            prio_op [NUM_REG];

  always_comb begin
    ctrl_op = decode(addr, A_CTRL);
    for (int k = 0; k < NUM_REG; k++) begin
      prio_op[k] = decode(addr, A_PRIO0 + PRIO_STRIDE * k);
    end
  end

  assign soft_rst = wr_en && (ctrl_op == OP_WR || ctrl_op == OP_SET) && wdata[C_SRST];

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      ctrl_q     <= '0;
      vbase      <= '0;
      prio_words <= '0;
    end else if (wr_en) begin
      if (ctrl_op != OP_NONE) begin
        ctrl_q <= apply_op(ctrl_op, ctrl_q, wdata) & CMASK;
      end
      if (addr == ADDR_W'(A_VBASE)) begin
        vbase <= wdata;
      end
      for (int k = 0; k < NUM_REG; k++) begin
        if (prio_op[k] != OP_NONE) begin
          prio_words[k] <= apply_op(prio_op[k], prio_words[k], wdata) & PMASK;
        end
      end
    end
  end

  assign ctrl_word = ctrl_q;
  assign ctl_rse   = ctrl_q[C_RSE];
  assign ctl_final = ctrl_q[C_FINAL];

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam int R = n / SPR;
    localparam int B = (n % SPR) * LANE_W;
    assign src_lvl[n] = prio_words[R][B + F_LVL_LO +: LVL_W];
    assign src_en[n]  = prio_words[R][B + F_EN];
    assign src_frc[n] = prio_words[R][B + F_FORCE];
  end

  AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !soft_rst && ctrl_op == OP_CLR) |=> ((ctrl_q & $past(wdata)) == '0)) // R3
    else $error("clear alias left bits set");

  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !soft_rst && ctrl_op == OP_SET) |=>
      ((ctrl_q & $past(wdata & CMASK)) == $past(wdata & CMASK))) // R3
    else $error("set alias missed bits");

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int ID_W = $clog2(NUM_SRC)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_SRC-1:0]            pend,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
  output logic                          win_vld,
  output logic [ID_W-1:0]               win_id,
  output lvl_t                          win_lvl
);

  logic [NUM_LVL-1:0] lvl_any;
  logic [ID_W-1:0]    lvl_first [NUM_LVL];

  // per level: any hit, and the lowest-numbered hit
  for (genvar L = 0; L < NUM_LVL; L++) begin : g_lvl
    logic [NUM_SRC-1:0] hit;
    logic [ID_W-1:0]    first;
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_hit
      assign hit[s] = pend[s] && (lvl[s] == LVL_W'(L));
    end
    always_comb begin
      first = '0;
      for (int s = NUM_SRC - 1; s >= 0; s--) begin
        if (hit[s]) first = ID_W'(s);
      end
    end
    assign lvl_any[L]   = |hit;
    assign lvl_first[L] = first;
  end

  // highest non-empty level takes it
  always_comb begin
    win_vld = |lvl_any;
    win_id  = '0;
    win_lvl = '0;
    for (int L = 0; L < NUM_LVL; L++) begin
      if (lvl_any[L]) begin
        win_id  = lvl_first[L];
        win_lvl = lvl_t'(L);
      end
    end
  end

  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (rst)
    win_vld |-> pend[win_id]) // R5
    else $error("winner is not pending");

  AST_IDLE_NO_WIN: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |-> !win_vld) // R10
    else $error("winner with nothing pending");

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
    AST_NO_HIGHER: assert property (@(posedge clk) disable iff (rst)
      pend[s] |-> (lvl[s] <= win_lvl)) // R5
      else $error("a higher level lost");
    AST_TIE_LOW: assert property (@(posedge clk) disable iff (rst)
      (pend[s] && lvl[s] == win_lvl) |-> (win_id <= ID_W'(s))) // R5
      else $error("tie not broken toward low index");
  end

endmodule

// File: rtl/irqc_svc.sv
module irqc_svc
  import irqc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               enter,
  input  lvl_t               enter_lvl,
  input  logic               ack,
  input  logic [NUM_LVL-1:0] ack_mask,
  input  logic               win_vld,
  input  lvl_t               win_lvl,
  output logic [NUM_LVL-1:0] isv,
  output logic               eligible
);

  logic [NUM_LVL-1:0] ge_mask;
  logic [NUM_LVL-1:0] set_bits;
  logic [NUM_LVL-1:0] clr_bits;

  assign ge_mask  = {NUM_LVL{1'b1}} << win_lvl;
  assign eligible = win_vld && ((isv & ge_mask) == '0);
  assign set_bits = enter ? (NUM_LVL'(1) << enter_lvl) : '0;
  assign clr_bits = ack ? ack_mask : '0;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      isv <= '0;
    end else begin
      isv <= (isv & ~clr_bits) | set_bits;
    end
  end

  AST_ENTER_MARKS: assert property (@(posedge clk) disable iff (rst)
    (enter && !clr) |=> isv[$past(enter_lvl)]) // R7
    else $error("vector read did not mark level");

  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (ack && !enter && !clr) |=> ((isv & $past(ack_mask)) == '0)) // R9
    else $error("acknowledged level still in service");

  AST_ONLY_HIGHER: assert property (@(posedge clk) disable iff (rst)
    enter |-> ((isv & ({NUM_LVL{1'b1}} << enter_lvl)) == '0)) // R8
    else $error("entered service at or below active level");

endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  localparam int ID_W    = $clog2(NUM_SRC),
  localparam int SPR     = DATA_W / LANE_W,
  localparam int NUM_REG = (NUM_SRC + SPR - 1) / SPR
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_req,
  output logic               irq_o
);

  logic                          wr_en, rd_en;
  logic                          soft_rst;
  logic [DATA_W-1:0]             ctrl_word;
  logic                          ctl_rse, ctl_final;
  logic [DATA_W-1:0]             vbase;
  logic [NUM_REG-1:0][DATA_W-1:0] prio_words;
  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;
  logic [NUM_SRC-1:0]            src_en, src_frc, pend;
  logic                          win_vld;
  logic [ID_W-1:0]               win_id;
  lvl_t                          win_lvl;
  logic [NUM_LVL-1:0]            isv;
  logic                          eligible;
  logic                          vec_rd, enter, lack_wr;
  logic [DATA_W-1:0]             vec_val, rd_next;

  assign wr_en   = bus_sel && bus_wr;
  assign rd_en   = bus_sel && !bus_wr;
  assign vec_rd  = rd_en && (bus_addr == ADDR_W'(A_VEC));
  assign lack_wr = wr_en && (bus_addr == ADDR_W'(A_LACK));

  irqc_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .soft_rst   (soft_rst),
    .ctrl_word  (ctrl_word),
    .ctl_rse    (ctl_rse),
    .ctl_final  (ctl_final),
    .vbase      (vbase),
    .prio_words (prio_words),
    .src_lvl    (src_lvl),
    .src_en     (src_en),
    .src_frc    (src_frc)
  );

  assign pend = (src_req | src_frc) & src_en;

  irqc_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk     (clk),
    .rst     (rst),
    .pend    (pend),
    .lvl     (src_lvl),
    .win_vld (win_vld),
    .win_id  (win_id),
    .win_lvl (win_lvl)
  );

  assign enter = vec_rd && ctl_rse && eligible;

  irqc_svc u_svc (
    .clk       (clk),
    .rst       (rst),
    .clr       (soft_rst),
    .enter     (enter),
    .enter_lvl (win_lvl),
    .ack       (lack_wr),
    .ack_mask  (bus_wdata[NUM_LVL-1:0]),
    .win_vld   (win_vld),
    .win_lvl   (win_lvl),
    .isv       (isv),
    .eligible  (eligible)
  );

  assign vec_val = eligible ? (vbase + (DATA_W'(win_id) << 2)) : vbase;

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(A_CTRL))       rd_next = ctrl_word;
    else if (bus_addr == ADDR_W'(A_VEC))   rd_next = vec_val;
    else if (bus_addr == ADDR_W'(A_VBASE)) rd_next = vbase;
    for (int k = 0; k < NUM_REG; k++) begin
      if (bus_addr == ADDR_W'(A_PRIO0 + PRIO_STRIDE * k)) rd_next = prio_words[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      if (rd_en) bus_rdata <= rd_next;
      irq_o <= ctl_final && eligible;
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ctl_final)) // R4
    else $error("irq raised with final enable off");

  AST_SRST_QUIET: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!irq_o && bus_rdata == '0 && isv == '0)) // R11
    else $error("soft reset left state behind");

  AST_IDLE_VEC: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && !eligible && !soft_rst) |=> (bus_rdata == $past(vbase))) // R10
    else $error("idle vector read not equal to base");

  AST_DISABLED_OUT: assert property (@(posedge clk) disable iff (rst)
    (src_en == '0) |=> !irq_o) // R12
    else $error("irq with every source disabled");

endmodule

// File: tb/irq_collector_test.sv
module irq_collector_test;

  localparam int NS = 16;
  localparam logic [31:0] VB = 32'h8000_1000;
  localparam logic [7:0] AC = 8'h00, AV = 8'h04, AL = 8'h05, AB = 8'h06, AP = 8'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NS-1:0] src_req = '0;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int m_lvl [NS];
  bit m_en  [NS];
  bit m_frc [NS];

  always #10 clk = ~clk;

  irq_collector uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic set_req(input logic [NS-1:0] v);
    @(negedge clk);
    src_req = v;
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    @(negedge clk);
    chk(tag, {31'd0, irq_o}, {31'd0, exp});
  endtask

  function automatic logic [7:0] src_byte(input int n);
    return {4'd0, m_frc[n], m_en[n], 2'(m_lvl[n])};
  endfunction

  function automatic logic [31:0] reg_word(input int k);
    logic [31:0] w = '0;
    for (int b = 0; b < 4; b++) w |= 32'(src_byte(4 * k + b)) << (8 * b);
    return w;
  endfunction

  // program one source via clear alias then set alias
  task automatic prog_src(input int n);
    logic [7:0] a;
    a = AP + 8'(4 * (n / 4));
    wr(a + 8'd2, 32'h0F << (8 * (n % 4)));
    wr(a + 8'd1, 32'(src_byte(n)) << (8 * (n % 4)));
  endtask

  task automatic zero_all();
    for (int s = 0; s < NS; s++) begin m_lvl[s] = 0; m_en[s] = 0; m_frc[s] = 0; end
    for (int k = 0; k < NS / 4; k++) wr(AP + 8'(4 * k), 32'd0);
  endtask

  function automatic logic [NS-1:0] pend_of(input logic [NS-1:0] req);
    logic [NS-1:0] p;
    for (int s = 0; s < NS; s++) p[s] = (req[s] | m_frc[s]) & m_en[s];
    return p;
  endfunction

  function automatic logic [31:0] exp_vec(input logic [NS-1:0] p);
    int best = -1;
    int bl = -1;
    for (int s = 0; s < NS; s++) begin
      if (p[s] && m_lvl[s] > bl) begin best = s; bl = m_lvl[s]; end
    end
    return (best < 0) ? VB : VB + 32'(4 * best);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    logic [NS-1:0] rq;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    rd_chk("R1 ctrl", AC, 32'd0);
    rd_chk("R1 vbase", AB, 32'd0);
    for (int k = 0; k < NS / 4; k++) rd_chk("R1 prio reg", AP + 8'(4 * k), 32'd0);
    rd_chk("R1 vector idle", AV, 32'd0);

    wr(AB, VB);
    rd_chk("R6 vbase readback", AB, VB);
    wr(AC, 32'h3);
    rd_chk("R3 ctrl plain write", AC, 32'h3);

    // R2 R6 R7 R9 R12: every source alone, all request lines high
    for (int n = 0; n < NS; n++) begin
      zero_all();
      m_lvl[n] = n % 4; m_en[n] = 1;
      prog_src(n);
      rd_chk("R2 byte lane readback", AP + 8'(4 * (n / 4)), reg_word(n / 4));
      set_req('1);
      chk_irq("R12 only enabled source raises irq", 1'b1);
      rd_chk("R6 vector of single source", AV, VB + 32'(4 * n));
      chk_irq("R7 level now in service", 1'b0);
      wr(AL, 32'(1) << ((n + 1) % 4));
      chk_irq("R9 other level ack keeps service", 1'b0);
      wr(AL, 32'(1) << (n % 4));
      chk_irq("R9 ack releases level", 1'b1);
      set_req('0);
      chk_irq("R4 irq drops with request", 1'b0);
    end

    // R5: arbitration sweep, side effects off
    wr(AC, 32'h2);
    lfsr = 16'hACE1;
    for (int t = 0; t < 48; t++) begin
      for (int s = 0; s < NS; s++) begin
        m_lvl[s] = (s * 3 + t + (s >> 2) * t) % 4;
        m_en[s]  = ((s + t) % 5) != 0;
        m_frc[s] = 0;
      end
      for (int k = 0; k < NS / 4; k++) wr(AP + 8'(4 * k), reg_word(k));
      rq = (t % 8 == 7) ? '0 : lfsr;
      set_req(rq);
      chk_irq("R5 irq follows pending", |pend_of(rq));
      rd_chk("R5 winner vector", AV, exp_vec(pend_of(rq)));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    set_req('0);

    // R8: nesting by level
    wr(AC, 32'h3);
    zero_all();
    m_lvl[0] = 1; m_lvl[1] = 2; m_lvl[2] = 2; m_lvl[3] = 3;
    for (int s = 0; s < 4; s++) m_en[s] = 1;
    for (int s = 0; s < 4; s++) prog_src(s);
    set_req(16'h0001);
    chk_irq("R8 first request", 1'b1);
    rd_chk("R8 vector src0", AV, VB);
    chk_irq("R8 level1 in service", 1'b0);
    set_req(16'h0003);
    chk_irq("R8 higher level preempts", 1'b1);
    rd_chk("R8 vector src1", AV, VB + 32'd4);
    chk_irq("R8 level2 in service", 1'b0);
    set_req(16'h0007);
    chk_irq("R8 equal level masked", 1'b0);
    set_req(16'h000F);
    chk_irq("R8 level3 preempts", 1'b1);
    rd_chk("R8 vector src3", AV, VB + 32'd12);
    chk_irq("R8 level3 in service", 1'b0);
    wr(AL, 32'h8);
    chk_irq("R9 ack level3 reopens", 1'b1);
    set_req(16'h0007);
    chk_irq("R8 level2 still masked", 1'b0);
    wr(AL, 32'h4);
    chk_irq("R9 ack level2", 1'b1);
    rd_chk("R5 tie to lowest index", AV, VB + 32'd4);
    set_req(16'h0005);
    chk_irq("R8 src2 masked by level2", 1'b0);
    wr(AL, 32'h4);
    chk_irq("R9 ack level2 again", 1'b1);
    rd_chk("R6 vector src2", AV, VB + 32'd8);
    wr(AL, 32'h6);
    set_req('0);
    chk_irq("R9 all released, no request", 1'b0);

    // R7 without side effects, R4 final enable, R3 ctrl aliases
    wr(AC, 32'h2);
    zero_all();
    m_en[4] = 1;
    prog_src(4);
    set_req(16'h0010);
    chk_irq("R4 irq with final enable", 1'b1);
    rd_chk("R7 vector read no side effect", AV, VB + 32'd16);
    rd_chk("R7 second read same", AV, VB + 32'd16);
    chk_irq("R7 irq still high", 1'b1);
    wr(AC + 8'd2, 32'h2);
    rd_chk("R3 ctrl clear alias", AC, 32'h0);
    chk_irq("R4 final enable off", 1'b0);
    wr(AC + 8'd1, 32'h3);
    rd_chk("R3 ctrl set alias", AC, 32'h3);
    chk_irq("R4 final enable back on", 1'b1);
    set_req('0);
    chk_irq("R4 no request", 1'b0);

    // R12: all disabled
    zero_all();
    set_req('1);
    chk_irq("R12 disabled sources quiet", 1'b0);
    rd_chk("R12 vector base when disabled", AV, VB);
    set_req('0);

    // R10: idle vector read marks nothing
    rd_chk("R10 idle vector", AV, VB);
    m_en[0] = 1;
    prog_src(0);
    set_req(16'h0001);
    chk_irq("R10 level0 not marked", 1'b1);
    rd_chk("R6 vector src0 level0", AV, VB);
    wr(AL, 32'hF);
    set_req('0);

    // force bit, then soft reset
    zero_all();
    m_lvl[9] = 3; m_en[9] = 1; m_frc[9] = 1;
    prog_src(9);
    chk_irq("R2 force raises irq", 1'b1);
    rd_chk("R2 forced vector", AV, VB + 32'd36);
    chk_irq("R7 forced level in service", 1'b0);
    wr(AC + 8'd1, 32'h8000_0000);
    @(negedge clk);
    chk("R11 irq after soft reset", {31'd0, irq_o}, 32'd0);
    rd_chk("R11 ctrl cleared", AC, 32'd0);
    rd_chk("R11 prio cleared", AP + 8'd8, 32'd0);
    rd_chk("R11 vbase cleared", AB, 32'd0);
    wr(AB, VB);
    wr(AC, 32'h3);
    prog_src(9);
    chk_irq("R11 service state cleared", 1'b1);
    wr(AP + 8'd8 + 8'd2, 32'h1 << (8 + 3));
    chk_irq("R3 prio clear alias drops force", 1'b0);
    rd_chk("R3 prio after clear alias", AP + 8'd8, 32'h0000_0700);

    finish_run();
  end

endmodule